// File: doc/BRIEF.md
# Double-Buffered Filter Coefficient Bank

This block stores the coefficients of an audio filter engine in two banks, A and B. Each coefficient is a 16-bit two's complement value in 1.15 fixed-point format. The filter engine reads one coefficient per cycle from the active bank, and the result arrives one cycle after the engine presents its index. A host loads and inspects coefficients one byte at a time through a request/response port. Each host address selects a coefficient index and a byte half, and each request also names a bank.

When the adaptive mode is on, the host can retune the filters while audio is running. Writes made during playback always go to the bank that the engine is not using. The host then raises a swap request, and the banks exchange at the next sample-period strobe. The request bit clears by itself once the swap has happened, and the in-use flag shows which bank is active. When the adaptive mode is off and the engine is running, the coefficients are locked and every host access is refused.

The host request channel is valid/ready. A request is accepted on a cycle where both `host_req_valid` and `host_req_ready` are high. Ready drops only on the single cycle in which a bank swap is applied, and the host must hold its request until it is accepted. Every accepted request, read or write, produces exactly one response on the following cycle. The response carries no back-pressure: the host must take it in that cycle.

Top module: `coef_dbuf_bank`

## Requirements
- R1: After reset, the in-use flag and the swap-request bit read 0, every stored coefficient in both banks is 0, and no host response is pending.
- R2: While `eng_run` is 0, a host write updates only the bank named by `host_req_bank` (0 = bank A, 1 = bank B), and a host read returns a byte of that same bank.
- R3: Host address bit 0 selects the byte half (0 = low byte, 1 = high byte), and the upper address bits give the coefficient index. A low-byte write only latches the byte. A high-byte write stores the coefficient {high byte, last latched low byte} in a single cycle, so neither the engine nor the host ever sees a half-written coefficient.
- R4: While `eng_run` is 1 and `adapt_en` is 1, a host write lands in the bank that is not in use, whatever `host_req_bank` says.
- R5: While `eng_run` is 1 and `adapt_en` is 0, every accepted host request gets a response with `host_rsp_err`=1 and read data 0x00, and no coefficient changes.
- R6: A `swap_set` pulse while running in adaptive mode sets `swap_pend`. At the first later cycle with `sample_start`=1, the banks exchange: `bank_in_use` toggles (0 = bank A active, 1 = bank B active) and `swap_pend` returns to 0, both visible after that clock edge.
- R7: A swap request made while `eng_run` or `adapt_en` is 0 is ignored. A pending request is dropped when either input falls to 0, and `bank_in_use` does not change.
- R8: `eng_coef` presents, one clock after `eng_addr`, the coefficient at that index in the bank in use at the time of the request.
- R9: Each accepted host request gives exactly one response, one cycle later. `host_rsp_valid` is 0 in every other cycle, and `host_req_ready` is 0 only in the cycle in which a swap is applied.
- R10: While running in adaptive mode, host reads are redirected to the bank that is not in use, so the host can check values it has just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_run | input | 1 | Filter engine is running |
| sample_start | input | 1 | Strobe marking the start of a sample period |
| adapt_en | input | 1 | Enables double-buffered (adaptive) mode |
| swap_set | input | 1 | Pulse requesting a bank swap |
| swap_pend | output | 1 | Swap request bit; clears itself |
| bank_in_use | output | 1 | Active bank, 0 = A, 1 = B |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Host request accepted when high |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_bank | input | 1 | Addressed bank, 0 = A, 1 = B |
| host_req_addr | input | IDX_W+1 | {coefficient index, byte select} |
| host_req_wdata | input | 8 | Write byte |
| host_rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| host_rsp_err | output | 1 | Request refused because coefficients are locked |
| host_rsp_rdata | output | 8 | Read byte (0 for writes and refusals) |
| eng_addr | input | IDX_W | Engine coefficient index |
| eng_coef | output | 16 | Engine coefficient, one cycle latency |

## Verification
The bench first loads both banks while the engine is stopped and reads them back. A design that ignored the bank select, or mirrored writes into both banks, would return the wrong byte for an index written in only one bank. It writes a low byte alone and reads the coefficient before sending the high byte. A design that committed each byte on its own would expose a half value to the engine. During adaptive playback it writes with the active bank's address; a design without redirection would change the coefficient the engine is using right away. It also checks the swap timing against the strobe, swap requests made in the wrong mode, dropping a pending request by stopping the engine, refusal of accesses in the locked state, and the ready drop in the swap cycle.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int BYTE_W = 8;
  localparam int COEF_W = 2 * BYTE_W;
  localparam int NUM_BANKS = 2;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;
endpackage

// File: rtl/coef_swap_ctrl.sv
module coef_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic eng_run,
  input  logic adapt_en,
  input  logic swap_set,
  input  logic sample_start,
  output logic swap_pend,
  output logic bank_in_use,
  output logic swap_now
);
  logic armed;
  logic pend_q;
  logic use_q;

  assign armed    = eng_run && adapt_en;
  assign swap_now = armed && pend_q && sample_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      use_q  <= 1'b0;
    end else begin
      if (!armed)        pend_q <= 1'b0;
      else if (swap_now) pend_q <= 1'b0;
      else if (swap_set) pend_q <= 1'b1;
      if (swap_now) use_q <= ~use_q;
    end
  end

  assign swap_pend   = pend_q;
  assign bank_in_use = use_q;

  assert_swap_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_q != $past(use_q)) |-> ($past(sample_start) && $past(pend_q)));

  assert_pend_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!eng_run || !adapt_en) |=> !pend_q);

  assert_pend_clears_after_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && sample_start && eng_run && adapt_en) |=> !pend_q);
endmodule

// File: rtl/coef_host_path.sv
module coef_host_path #(
  parameter int IDX_W = 4,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       eng_run,
  input  logic                       adapt_en,
  input  logic                       bank_in_use,
  input  logic                       swap_now,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic                       req_bank,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [coef_pkg::BYTE_W-1:0] req_wdata,
  input  logic [coef_pkg::COEF_W-1:0] rd_word,
  output logic                       tgt_bank,
  output logic [IDX_W-1:0]           tgt_idx,
  output logic                       wr_en,
  output logic [coef_pkg::COEF_W-1:0] wr_word,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [coef_pkg::BYTE_W-1:0] rsp_rdata
);
  import coef_pkg::*;

  logic              locked;
  logic              accept;
  logic              hi_sel;
  logic [BYTE_W-1:0] stage_lo_q;
  logic [BYTE_W-1:0] rd_byte;

  assign locked    = eng_run && !adapt_en;
  assign req_ready = !swap_now;
  assign accept    = req_valid && req_ready;
  assign hi_sel    = req_addr[0];
  assign tgt_idx   = req_addr[ADDR_W-1:1];
  assign tgt_bank  = eng_run ? ~bank_in_use : req_bank;
  assign wr_en     = accept && req_write && !locked && hi_sel;
  assign wr_word   = {req_wdata, stage_lo_q};
  assign rd_byte   = hi_sel ? rd_word[COEF_W-1:BYTE_W] : rd_word[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (accept && req_write && !locked && !hi_sel) stage_lo_q <= req_wdata;
      rsp_valid <= accept;
      rsp_err   <= accept && locked;
      rsp_rdata <= (accept && !req_write && !locked) ? rd_byte : '0;
    end
  end

  assert_locked_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && eng_run && !adapt_en) |=> (rsp_valid && rsp_err && rsp_rdata == '0));

  assert_one_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_stray_response_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);
endmodule

// File: rtl/coef_bank_store.sv
module coef_bank_store #(
  parameter int NUM_COEF = 16,
  localparam int IDX_W = $clog2(NUM_COEF)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic                        wr_bank,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [coef_pkg::COEF_W-1:0] wr_word,
  input  logic                        hrd_bank,
  input  logic [IDX_W-1:0]            hrd_idx,
  output logic [coef_pkg::COEF_W-1:0] hrd_word,
  input  logic                        eng_bank,
  input  logic [IDX_W-1:0]            eng_idx,
  output logic [coef_pkg::COEF_W-1:0] eng_word
);
  import coef_pkg::*;

  logic [NUM_COEF-1:0][COEF_W-1:0] all_banks [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_COEF-1:0][COEF_W-1:0] cells;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cells <= '0;
      else if (wr_en && (wr_bank == b[0])) cells[wr_idx] <= wr_word;
    end
    assign all_banks[b] = cells;
  end

  assign hrd_word = all_banks[hrd_bank][hrd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eng_word <= '0;
    else        eng_word <= all_banks[eng_bank][eng_idx];
  end
endmodule

// File: rtl/coef_dbuf_bank.sv
module coef_dbuf_bank #(
  parameter int NUM_COEF = 16,
  localparam int IDX_W = $clog2(NUM_COEF),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_run,
  input  logic              sample_start,
  input  logic              adapt_en,
  input  logic              swap_set,
  output logic              swap_pend,
  output logic              bank_in_use,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic              host_req_write,
  input  logic              host_req_bank,
  input  logic [ADDR_W-1:0] host_req_addr,
  input  logic [7:0]        host_req_wdata,
  output logic              host_rsp_valid,
  output logic              host_rsp_err,
  output logic [7:0]        host_rsp_rdata,
  input  logic [IDX_W-1:0]  eng_addr,
  output logic [15:0]       eng_coef
);
  import coef_pkg::*;

  logic              swap_now;
  logic              tgt_bank;
  logic [IDX_W-1:0]  tgt_idx;
  logic              bank_we;
  logic [COEF_W-1:0] bank_wword;
  logic [COEF_W-1:0] host_word;

  coef_swap_ctrl u_swap (
    .clk          (clk),
    .rst_n        (rst_n),
    .eng_run      (eng_run),
    .adapt_en     (adapt_en),
    .swap_set     (swap_set),
    .sample_start (sample_start),
    .swap_pend    (swap_pend),
    .bank_in_use  (bank_in_use),
    .swap_now     (swap_now)
  );

  coef_host_path #(.IDX_W(IDX_W)) u_host (
    .clk         (clk),
    .rst_n       (rst_n),
    .eng_run     (eng_run),
    .adapt_en    (adapt_en),
    .bank_in_use (bank_in_use),
    .swap_now    (swap_now),
    .req_valid   (host_req_valid),
    .req_ready   (host_req_ready),
    .req_write   (host_req_write),
    .req_bank    (host_req_bank),
    .req_addr    (host_req_addr),
    .req_wdata   (host_req_wdata),
    .rd_word     (host_word),
    .tgt_bank    (tgt_bank),
    .tgt_idx     (tgt_idx),
    .wr_en       (bank_we),
    .wr_word     (bank_wword),
    .rsp_valid   (host_rsp_valid),
    .rsp_err     (host_rsp_err),
    .rsp_rdata   (host_rsp_rdata)
  );

  coef_bank_store #(.NUM_COEF(NUM_COEF)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bank_we),
    .wr_bank  (tgt_bank),
    .wr_idx   (tgt_idx),
    .wr_word  (bank_wword),
    .hrd_bank (tgt_bank),
    .hrd_idx  (tgt_idx),
    .hrd_word (host_word),
    .eng_bank (bank_in_use),
    .eng_idx  (eng_addr),
    .eng_word (eng_coef)
  );

  assert_run_write_inactive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && eng_run) |-> (tgt_bank != bank_in_use));

  assert_stopped_write_addressed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we && !eng_run) |-> (tgt_bank == host_req_bank));

  assert_ready_drop_only_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req_ready |=> (bank_in_use != $past(bank_in_use)));
endmodule

// File: tb/test_coef_dbuf_bank.sv
module test_coef_dbuf_bank;
  localparam int NUM_COEF = 16;
  localparam int IDX_W = $clog2(NUM_COEF);
  localparam int ADDR_W = IDX_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eng_run = 1'b0, sample_start = 1'b0, adapt_en = 1'b0, swap_set = 1'b0;
  logic swap_pend, bank_in_use;
  logic host_req_valid = 1'b0, host_req_write = 1'b0, host_req_bank = 1'b0;
  logic host_req_ready;
  logic [ADDR_W-1:0] host_req_addr = '0;
  logic [7:0] host_req_wdata = '0;
  logic host_rsp_valid, host_rsp_err;
  logic [7:0] host_rsp_rdata;
  logic [IDX_W-1:0] eng_addr = '0;
  logic [15:0] eng_coef;

  int n_tests = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  coef_dbuf_bank #(.NUM_COEF(NUM_COEF)) i_coef_dbuf_bank (
    .clk(clk), .rst_n(rst_n), .eng_run(eng_run), .sample_start(sample_start),
    .adapt_en(adapt_en), .swap_set(swap_set), .swap_pend(swap_pend),
    .bank_in_use(bank_in_use), .host_req_valid(host_req_valid),
    .host_req_ready(host_req_ready), .host_req_write(host_req_write),
    .host_req_bank(host_req_bank), .host_req_addr(host_req_addr),
    .host_req_wdata(host_req_wdata), .host_rsp_valid(host_rsp_valid),
    .host_rsp_err(host_rsp_err), .host_rsp_rdata(host_rsp_rdata),
    .eng_addr(eng_addr), .eng_coef(eng_coef)
  );

  // {write, bank, addr(5), data(8), expected read byte(8)}, all with the engine stopped
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 1'b0, 5'd6,  8'h34, 8'h00},
    {1'b1, 1'b0, 5'd7,  8'h12, 8'h00},
    {1'b1, 1'b1, 5'd6,  8'hCD, 8'h00},
    {1'b1, 1'b1, 5'd7,  8'hAB, 8'h00},
    {1'b1, 1'b0, 5'd30, 8'hFF, 8'h00},
    {1'b1, 1'b0, 5'd31, 8'h7F, 8'h00},
    {1'b1, 1'b1, 5'd0,  8'h00, 8'h00},
    {1'b1, 1'b1, 5'd1,  8'h80, 8'h00},
    {1'b0, 1'b0, 5'd6,  8'h00, 8'h34},
    {1'b0, 1'b0, 5'd7,  8'h00, 8'h12},
    {1'b0, 1'b1, 5'd7,  8'h00, 8'hAB},
    {1'b0, 1'b1, 5'd6,  8'h00, 8'hCD},
    {1'b0, 1'b0, 5'd31, 8'h00, 8'h7F},
    {1'b0, 1'b1, 5'd1,  8'h00, 8'h80},
    {1'b0, 1'b0, 5'd0,  8'h00, 8'h00},
    {1'b0, 1'b1, 5'd30, 8'h00, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input logic wr, input logic bank, input logic [ADDR_W-1:0] addr,
                         input logic [7:0] data, output logic rv, output logic err,
                         output logic [7:0] rd);
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = wr; host_req_bank = bank;
    host_req_addr = addr; host_req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    rv = host_rsp_valid; err = host_rsp_err; rd = host_rsp_rdata;
    host_req_valid = 1'b0;
  endtask

  task automatic eng_read(input logic [IDX_W-1:0] idx, output logic [15:0] v);
    @(negedge clk);
    eng_addr = idx;
    @(negedge clk);
    v = eng_coef;
  endtask

  task automatic pulse_swap();
    @(negedge clk); swap_set = 1'b1;
    @(negedge clk); swap_set = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic rv, err;
    logic [7:0] rd;
    logic [15:0] ev;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_use after reset", bank_in_use, 0);
    chk("R1 swap_pend after reset", swap_pend, 0);
    chk("R1 rsp_valid after reset", host_rsp_valid, 0);
    eng_read(4'd9, ev);
    chk("R1 engine coef after reset", ev, 16'h0000);

    // R2: table walk with engine stopped
    for (int i = 0; i < NV; i++) begin
      host_op(VEC[i][22], VEC[i][21], VEC[i][20:16], VEC[i][15:8], rv, err, rd);
      chk($sformatf("R2 vec %0d valid", i), rv, 1);
      chk($sformatf("R2 vec %0d err", i), err, 0);
      chk($sformatf("R2 vec %0d rdata", i), rd, VEC[i][7:0]);
    end

    // R8: engine reads bank A while in_use = 0
    eng_read(4'd3, ev);
    chk("R8 engine idx3 bank A", ev, 16'h1234);
    eng_read(4'd15, ev);
    chk("R8 engine idx15 bank A", ev, 16'h7FFF);

    // R3: half-written coefficient stays invisible
    host_op(1'b1, 1'b0, 5'd10, 8'h11, rv, err, rd);
    eng_read(4'd5, ev);
    chk("R3 engine after low byte only", ev, 16'h0000);
    host_op(1'b0, 1'b0, 5'd10, 8'h00, rv, err, rd);
    chk("R3 host low byte before commit", rd, 8'h00);
    host_op(1'b1, 1'b0, 5'd11, 8'h22, rv, err, rd);
    eng_read(4'd5, ev);
    chk("R3 engine after high byte", ev, 16'h2211);

    // R7: swap requests in the wrong mode are ignored
    pulse_swap();
    chk("R7 swap ignored when stopped", swap_pend, 0);
    @(negedge clk); eng_run = 1'b1; adapt_en = 1'b0;
    pulse_swap();
    chk("R7 swap ignored with adaptive off", swap_pend, 0);
    @(negedge clk); adapt_en = 1'b1;
    pulse_swap();
    chk("R6 swap_pend set while armed", swap_pend, 1);
    @(negedge clk); eng_run = 1'b0;
    @(negedge clk);
    chk("R7 pending dropped on stop", swap_pend, 0);
    @(negedge clk); sample_start = 1'b1;
    @(negedge clk); sample_start = 1'b0;
    chk("R7 in_use unchanged", bank_in_use, 0);

    // R5: locked access
    @(negedge clk); eng_run = 1'b1; adapt_en = 1'b0;
    host_op(1'b1, 1'b0, 5'd7, 8'hEE, rv, err, rd);
    chk("R5 locked write err", err, 1);
    host_op(1'b0, 1'b0, 5'd7, 8'h00, rv, err, rd);
    chk("R5 locked read err", err, 1);
    chk("R5 locked read data", rd, 8'h00);
    @(negedge clk); eng_run = 1'b0;
    host_op(1'b0, 1'b0, 5'd7, 8'h00, rv, err, rd);
    chk("R5 value untouched by locked write", rd, 8'h12);

    // R4 / R10: running adaptive, in_use = 0 -> writes to B
    @(negedge clk); eng_run = 1'b1; adapt_en = 1'b1;
    host_op(1'b1, 1'b0, 5'd6, 8'h78, rv, err, rd);
    host_op(1'b1, 1'b0, 5'd7, 8'h56, rv, err, rd);
    chk("R4 write accepted", err, 0);
    eng_read(4'd3, ev);
    chk("R4 active bank unchanged", ev, 16'h1234);
    host_op(1'b0, 1'b0, 5'd7, 8'h00, rv, err, rd);
    chk("R10 read redirected to inactive", rd, 8'h56);

    // R6: swap at sample boundary
    pulse_swap();
    chk("R6 pend before boundary", swap_pend, 1);
    chk("R6 no swap before boundary", bank_in_use, 0);
    @(negedge clk); sample_start = 1'b1;
    #1;
    chk("R9 ready low in swap cycle", host_req_ready, 0);
    @(negedge clk); sample_start = 1'b0;
    chk("R6 in_use toggled", bank_in_use, 1);
    chk("R6 pend self-cleared", swap_pend, 0);
    chk("R9 ready back high", host_req_ready, 1);
    eng_read(4'd3, ev);
    chk("R8 engine reads new bank B", ev, 16'h5678);

    // R4: in_use = 1 -> writes addressed to B land in A
    host_op(1'b1, 1'b1, 5'd6, 8'h9A, rv, err, rd);
    host_op(1'b1, 1'b1, 5'd7, 8'hBC, rv, err, rd);
    eng_read(4'd3, ev);
    chk("R4 active B unchanged", ev, 16'h5678);
    @(negedge clk); eng_run = 1'b0;
    host_op(1'b0, 1'b0, 5'd7, 8'h00, rv, err, rd);
    chk("R4 write landed in A high", rd, 8'hBC);
    host_op(1'b0, 1'b0, 5'd6, 8'h00, rv, err, rd);
    chk("R4 write landed in A low", rd, 8'h9A);
    host_op(1'b0, 1'b1, 5'd7, 8'h00, rv, err, rd);
    chk("R2 bank B kept value", rd, 8'h56);
    @(negedge clk);
    chk("R9 no response when idle", host_rsp_valid, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule